// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block models the status side of a NOR-style flash memory while an internal program or erase operation runs. A command decoder elsewhere sends a one-cycle pulse when a program or erase command sequence has been fully written. With that pulse come protection flags for the addressed sectors. The block then runs the operation on internal cycle counters. While the operation runs, it answers read cycles with a status byte whose toggle bit inverts once per completed read. Outside an operation, it passes array data through.

A read is active while both the output-enable and chip-enable inputs are low. The read ends when either one of them rises. Only the end of a read flips the toggle bit, so the returned byte stays steady for the whole strobe.

An erase first runs a command time-out window and then the erase itself. The erase may be suspended, and a program may run while it is suspended. A resume continues the erase from the cycles it had left. A program to a protected sector, or an erase whose selected sectors are all protected, performs no operation. Instead it toggles for a fixed short window. The busy indicator is a pull-down enable for a shared open-drain line: it only sinks current or releases the line.

Top module: `flash_status_resp`

## Requirements
- R1: After synchronous reset the block is idle, `ry_sink` is 0 and `dout` is 0.
- R2: While no read is active, `dout` is 0. In idle or erase-suspend-read, a read returns `array_data`, and the toggle bit does not change.
- R3: While an operation is busy, a read returns a status byte with bit 6 equal to the toggle bit and every other bit 0. Each completed read inverts the toggle bit, at any address.
- R4: A read ends when either `oe_n` or `ce_n` rises. Both endings count as one read for toggling.
- R5: A program to an unprotected sector keeps `ry_sink` at 1 for exactly PROG_CYC cycles after the command pulse. After that, reads return array data.
- R6: A program to a protected sector toggles with `ry_sink` at 1 for exactly PPROT_CYC cycles, then returns to array read.
- R7: An erase is busy and toggling from the command pulse, through ETMO_CYC time-out cycles and then ERASE_CYC erase cycles.
- R8: An erase whose selected sectors are all protected is busy for exactly EPROT_CYC cycles, then returns to array read.
- R9: A suspend request during the erase phase releases `ry_sink` on the next cycle and stops toggling. The erase counter is frozen while suspended.
- R10: A program command in erase-suspend drives `ry_sink` to 1 and toggles for its program window. It then returns to erase-suspend-read with `ry_sink` at 0.
- R11: A resume request in erase-suspend-read restarts the erase. It finishes after exactly the cycles that were left when it was suspended.
- R12: Commands in a busy state are ignored, suspend outside the erase phase is ignored, and resume outside erase-suspend-read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_cmd | input | 1 | One-cycle pulse: program command sequence complete |
| erase_cmd | input | 1 | One-cycle pulse: erase command sequence complete |
| prog_prot | input | 1 | Program target sector is protected (sampled with `prog_cmd`) |
| erase_all_prot | input | 1 | All selected erase sectors are protected (sampled with `erase_cmd`) |
| susp_req | input | 1 | One-cycle erase-suspend request |
| resume_req | input | 1 | One-cycle erase-resume request |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| array_data | input | DATA_W | Array read data for the current address |
| dout | output | DATA_W | Registered read data or status byte |
| ry_sink | output | 1 | 1 = pull the shared ready/busy line low (busy) |

## Verification
The checker assumes that all inputs are synchronous to `clk` and that command, suspend and resume inputs are single-cycle pulses. It also assumes the protection flags are valid in the cycle of their command pulse. The bench changes inputs only on the falling clock edge and clears every pulse after exactly one cycle. It holds each read strobe for several cycles, and it places reads only where the busy state will not change before the strobe ends. This keeps the expected toggle value well defined. Counter windows are checked in the cycle just before and just at their expected end.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ETMO  = 3'd2,
    ST_ERASE = 3'd3,
    ST_EWIN  = 3'd4,
    ST_SUSP  = 3'd5,
    ST_SPROG = 3'd6
  } fsr_state_e;

  function automatic logic st_busy(input fsr_state_e s);
    return (s == ST_PROG) || (s == ST_ETMO) || (s == ST_ERASE) ||
           (s == ST_EWIN) || (s == ST_SPROG);
  endfunction
endpackage

// File: rtl/fsr_rd_strobe.sv
module fsr_rd_strobe (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  input  logic ce_n,
  output logic rd_act,
  output logic rd_end
);
  logic rd_q;

  assign rd_act = ~oe_n & ~ce_n;
  assign rd_end = rd_q & ~rd_act;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_act;
  end
endmodule

// File: rtl/fsr_timer.sv
module fsr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = run && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (load)                  cnt <= load_val;
    else if (run && cnt != '0)      cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PROG_CYC  = 40,
  parameter int PPROT_CYC = 8,
  parameter int ETMO_CYC  = 16,
  parameter int ERASE_CYC = 120,
  parameter int EPROT_CYC = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prog_cmd,
  input  logic             erase_cmd,
  input  logic             prog_prot,
  input  logic             erase_all_prot,
  input  logic             susp_req,
  input  logic             resume_req,
  input  logic             exp_a,
  input  logic             exp_b,
  output fsr_state_e       st_q,
  output fsr_state_e       st_n,
  output logic             load_a,
  output logic [CNT_W-1:0] val_a,
  output logic             load_b,
  output logic [CNT_W-1:0] val_b
);
  localparam logic [CNT_W-1:0] L_PROG  = CNT_W'(PROG_CYC);
  localparam logic [CNT_W-1:0] L_PPROT = CNT_W'(PPROT_CYC);
  localparam logic [CNT_W-1:0] L_ETMO  = CNT_W'(ETMO_CYC);
  localparam logic [CNT_W-1:0] L_ERASE = CNT_W'(ERASE_CYC);
  localparam logic [CNT_W-1:0] L_EPROT = CNT_W'(EPROT_CYC);

  always_comb begin
    st_n   = st_q;
    load_a = 1'b0;
    val_a  = '0;
    load_b = 1'b0;
    val_b  = '0;
    case (st_q)
      ST_IDLE: begin
        if (prog_cmd) begin
          load_b = 1'b1;
          val_b  = prog_prot ? L_PPROT : L_PROG;
          st_n   = ST_PROG;
        end else if (erase_cmd) begin
          load_a = 1'b1;
          val_a  = erase_all_prot ? L_EPROT : L_ETMO;
          st_n   = erase_all_prot ? ST_EWIN : ST_ETMO;
        end
      end
      ST_PROG:  if (exp_b) st_n = ST_IDLE;
      ST_ETMO: begin
        if (exp_a) begin
          load_a = 1'b1;
          val_a  = L_ERASE;
          st_n   = ST_ERASE;
        end
      end
      ST_ERASE: begin
        if (exp_a)         st_n = ST_IDLE;
        else if (susp_req) st_n = ST_SUSP;
      end
      ST_EWIN:  if (exp_a) st_n = ST_IDLE;
      ST_SUSP: begin
        if (prog_cmd) begin
          load_b = 1'b1;
          val_b  = prog_prot ? L_PPROT : L_PROG;
          st_n   = ST_SPROG;
        end else if (resume_req) begin
          st_n = ST_ERASE;
        end
      end
      ST_SPROG: if (exp_b) st_n = ST_SUSP;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_n;
  end
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import fsr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int TOG_BIT   = 6,
  parameter int PROG_CYC  = 40,
  parameter int PPROT_CYC = 8,
  parameter int ETMO_CYC  = 16,
  parameter int ERASE_CYC = 120,
  parameter int EPROT_CYC = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_cmd,
  input  logic              erase_cmd,
  input  logic              prog_prot,
  input  logic              erase_all_prot,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic              oe_n,
  input  logic              ce_n,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout,
  output logic              ry_sink
);
  localparam int MAX_AB = (PROG_CYC > PPROT_CYC) ? PROG_CYC : PPROT_CYC;
  localparam int MAX_CD = (ERASE_CYC > ETMO_CYC) ? ERASE_CYC : ETMO_CYC;
  localparam int MAX_E  = (MAX_CD > EPROT_CYC) ? MAX_CD : EPROT_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_E) ? MAX_AB : MAX_E;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  fsr_state_e       st_q, st_n;
  logic             rd_act, rd_end;
  logic             load_a, load_b, exp_a, exp_b, run_a, run_b;
  logic [CNT_W-1:0] val_a, val_b, cnt_a, cnt_b;
  logic             tog_q;
  logic [DATA_W-1:0] status_byte;

  fsr_rd_strobe u_strobe (
    .clk(clk), .rst(rst), .oe_n(oe_n), .ce_n(ce_n),
    .rd_act(rd_act), .rd_end(rd_end)
  );

  fsr_ctrl #(
    .CNT_W(CNT_W), .PROG_CYC(PROG_CYC), .PPROT_CYC(PPROT_CYC),
    .ETMO_CYC(ETMO_CYC), .ERASE_CYC(ERASE_CYC), .EPROT_CYC(EPROT_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .prog_cmd(prog_cmd), .erase_cmd(erase_cmd),
    .prog_prot(prog_prot), .erase_all_prot(erase_all_prot),
    .susp_req(susp_req), .resume_req(resume_req),
    .exp_a(exp_a), .exp_b(exp_b), .st_q(st_q), .st_n(st_n),
    .load_a(load_a), .val_a(val_a), .load_b(load_b), .val_b(val_b)
  );

  assign run_a = (st_q == ST_ETMO) || (st_q == ST_ERASE) || (st_q == ST_EWIN);
  assign run_b = (st_q == ST_PROG) || (st_q == ST_SPROG);

  fsr_timer #(.CNT_W(CNT_W)) u_tmr_erase (
    .clk(clk), .rst(rst), .load(load_a), .load_val(val_a),
    .run(run_a), .cnt(cnt_a), .expire(exp_a)
  );

  fsr_timer #(.CNT_W(CNT_W)) u_tmr_prog (
    .clk(clk), .rst(rst), .load(load_b), .load_val(val_b),
    .run(run_b), .cnt(cnt_b), .expire(exp_b)
  );

  always_comb begin
    status_byte          = '0;
    status_byte[TOG_BIT] = tog_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q   <= 1'b0;
      dout    <= '0;
      ry_sink <= 1'b0;
    end else begin
      if (rd_end && st_busy(st_q)) tog_q <= ~tog_q;
      if (!rd_act)                 dout  <= '0;
      else if (st_busy(st_q))      dout  <= status_byte;
      else                         dout  <= array_data;
      ry_sink <= st_busy(st_n);
    end
  end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import fsr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input fsr_state_e        st,
  input logic              rd_act,
  input logic              rd_end,
  input logic              tog,
  input logic [CNT_W-1:0]  cnt_a,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] dout,
  input logic              ry_sink
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!ry_sink && dout == '0)); // R1

  AST_IDLE_DATA: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && rd_act) |=> (dout == $past(array_data))); // R2

  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_act |=> (dout == '0)); // R2

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
    (rd_end && st_busy(st)) |=> (tog != $past(tog))); // R3

  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_end |=> $stable(tog)); // R2

  AST_SUSP_READY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SUSP) |-> !ry_sink); // R9

  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SUSP) |=> $stable(cnt_a)); // R11

  AST_SPROG_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SPROG) |-> ry_sink); // R10
endmodule

bind flash_status_resp fsr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .st(st_q), .rd_act(rd_act), .rd_end(rd_end),
  .tog(tog_q), .cnt_a(cnt_a), .array_data(array_data), .dout(dout),
  .ry_sink(ry_sink)
);

// File: tb/flash_status_resp_test.sv
module flash_status_resp_test;
  localparam int DW    = 8;
  localparam int P_PRG = 40;
  localparam int P_PPR = 8;
  localparam int P_TMO = 16;
  localparam int P_ERS = 120;
  localparam int P_EPR = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_cmd = 0, erase_cmd = 0, prog_prot = 0, erase_all_prot = 0;
  logic susp_req = 0, resume_req = 0, oe_n = 1, ce_n = 1;
  logic [DW-1:0] array_data = 8'hA5;
  logic [DW-1:0] dout;
  logic ry_sink;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit exp_tog = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_status_resp #(
    .DATA_W(DW), .TOG_BIT(6), .PROG_CYC(P_PRG), .PPROT_CYC(P_PPR),
    .ETMO_CYC(P_TMO), .ERASE_CYC(P_ERS), .EPROT_CYC(P_EPR)
  ) uut (
    .clk(clk), .rst(rst), .prog_cmd(prog_cmd), .erase_cmd(erase_cmd),
    .prog_prot(prog_prot), .erase_all_prot(erase_all_prot),
    .susp_req(susp_req), .resume_req(resume_req), .oe_n(oe_n), .ce_n(ce_n),
    .array_data(array_data), .dout(dout), .ry_sink(ry_sink)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // one read strobe; ends by raising ce_n if by_ce, else oe_n
  task automatic do_read(input bit by_ce, output logic [DW-1:0] val);
    oe_n = 0; ce_n = 0;
    repeat (3) @(negedge clk);
    val = dout;
    if (by_ce) ce_n = 1; else oe_n = 1;
    @(negedge clk);
    oe_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  // busy read: expect status byte with bit 6 = exp_tog, then model flips
  task automatic busy_read(input bit by_ce, input string tag);
    logic [DW-1:0] v;
    do_read(by_ce, v);
    check(v, {1'b0, exp_tog, 6'b0}, tag);
    exp_tog = ~exp_tog;
  endtask

  task automatic idle_read(input string tag);
    logic [DW-1:0] v;
    do_read(1'b0, v);
    check(v, array_data, tag);
  endtask

  task automatic pulse(ref logic sig, output int edge_cyc);
    sig = 1;
    @(negedge clk);
    edge_cyc = cyc;
    sig = 0;
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(ry_sink, 0, "R1 ry_sink after reset");
    check(dout, 0, "R1 dout after reset");
    exp_tog = 0;
    array_data = 8'hA5;
    idle_read("R2 idle read returns array");
    array_data = 8'h5A;
    idle_read("R2 idle read follows array");
    check(dout, 0, "R2 dout zero without read");
  endtask

  task automatic t_program;
    int c0;
    prog_prot = 0;
    pulse(prog_cmd, c0);
    check(ry_sink, 1, "R5 busy after program cmd");
    busy_read(0, "R3 program toggle read 1");
    busy_read(0, "R3 program toggle read 2");
    busy_read(1, "R4 read ended by ce_n");
    busy_read(1, "R4 second ce_n read");
    wait_to(c0 + P_PRG - 1);
    check(ry_sink, 1, "R5 busy just before end");
    wait_to(c0 + P_PRG);
    check(ry_sink, 0, "R5 ready at end");
    idle_read("R5 array data after program");
  endtask

  task automatic t_prot_program;
    int c0;
    prog_prot = 1;
    pulse(prog_cmd, c0);
    prog_prot = 0;
    check(ry_sink, 1, "R6 busy in protected window");
    wait_to(c0 + P_PPR - 1);
    check(ry_sink, 1, "R6 busy before window end");
    wait_to(c0 + P_PPR);
    check(ry_sink, 0, "R6 ready after short window");
    idle_read("R6 array read after protected program");
  endtask

  task automatic t_erase;
    int c0;
    erase_all_prot = 0;
    pulse(erase_cmd, c0);
    check(ry_sink, 1, "R7 busy in erase time-out");
    busy_read(0, "R7 toggle during time-out");
    wait_to(c0 + P_TMO + 5);
    busy_read(1, "R7 toggle during erase");
    wait_to(c0 + P_TMO + P_ERS - 1);
    check(ry_sink, 1, "R7 busy before erase end");
    wait_to(c0 + P_TMO + P_ERS);
    check(ry_sink, 0, "R7 ready after erase");
  endtask

  task automatic t_prot_erase;
    int c0;
    erase_all_prot = 1;
    pulse(erase_cmd, c0);
    erase_all_prot = 0;
    busy_read(0, "R8 toggle in protected erase window");
    wait_to(c0 + P_EPR - 1);
    check(ry_sink, 1, "R8 busy before window end");
    wait_to(c0 + P_EPR);
    check(ry_sink, 0, "R8 ready after window");
    idle_read("R8 array read after window");
  endtask

  task automatic t_suspend;
    int c0, cs, cp, cr, rem;
    logic [DW-1:0] v1, v2;
    pulse(erase_cmd, c0);
    wait_to(c0 + P_TMO + 30);
    pulse(susp_req, cs);
    rem = P_ERS - (cs - (c0 + P_TMO));
    check(ry_sink, 0, "R9 ready in suspend");
    array_data = 8'h3C;
    do_read(0, v1);
    do_read(1, v2);
    check(v1, 8'h3C, "R9 suspend read returns array");
    check(v2, 8'h3C, "R9 no toggle in suspend");
    pulse(prog_cmd, cp);
    check(ry_sink, 1, "R10 busy for program in suspend");
    busy_read(0, "R10 toggle program in suspend");
    wait_to(cp + P_PRG - 1);
    check(ry_sink, 1, "R10 busy before suspend-program end");
    wait_to(cp + P_PRG);
    check(ry_sink, 0, "R10 back to suspend-read");
    idle_read("R10 array read after suspend-program");
    wait_to(cyc + 200);
    check(ry_sink, 0, "R9 erase frozen while suspended");
    pulse(resume_req, cr);
    check(ry_sink, 1, "R11 busy after resume");
    busy_read(1, "R11 toggle resumes");
    wait_to(cr + rem - 1);
    check(ry_sink, 1, "R11 busy before remaining ends");
    wait_to(cr + rem);
    check(ry_sink, 0, "R11 ready after remaining cycles");
  endtask

  task automatic t_ignored;
    int c0, cx;
    pulse(prog_cmd, c0);
    wait_to(c0 + 10);
    pulse(susp_req, cx);
    pulse(prog_cmd, cx);
    pulse(erase_cmd, cx);
    wait_to(c0 + P_PRG - 1);
    check(ry_sink, 1, "R12 program not restarted");
    wait_to(c0 + P_PRG);
    check(ry_sink, 0, "R12 program ends on time");
    pulse(resume_req, cx);
    check(ry_sink, 0, "R12 resume in idle ignored");
    pulse(susp_req, cx);
    idle_read("R12 suspend in idle ignored");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_program();
    t_prot_program();
    t_erase();
    t_prot_erase();
    t_suspend();
    t_ignored();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule